// File: doc/BRIEF.md
# 480p Scan-Out Sequencer with Side Borders

This block produces the raster timing and colour stream for a 720x480 progressive display refreshed at 60 Hz. A divider turns the system clock into a pixel tick, one tick for every ten clocks by default (27 MHz pixels from a 270 MHz system clock). On each tick the block moves one pixel through a line and one line through a frame, and it registers the colour, the two active-low sync strobes and the data-enable for that pixel.

Each visible line has three parts. First comes a solid span drawn from one 24-bit colour input, then 640 image pixels pulled one word at a time from a ready/valid stream of 16-bit 5:6:5 words, then a second solid span drawn from another 24-bit colour input. Each image word is widened to 8 bits per channel. If no word is waiting when an image pixel is due, the block shows black for that pixel and sets a flag that stays set until reset.

Horizontal blanking has three fixed phases ahead of the visible region: a porch before sync, the sync pulse, and a porch before the visible pixels. Each frame has two sync lines, then the top blank lines, the active lines and the bottom blank lines. Every span length is a parameter.

Top module: `scan480_sequencer`

## Requirements
- R1: While reset is held, and until the first pixel tick after it, rgb_out is 0, de is 0, hsync_n and vsync_n are 1, underflow is 0 and pix_ready is 0.
- R2: The pixel tick falls once every CLK_DIV clocks. The first tick after reset comes on the CLK_DIV-th clock edge. rgb_out, de, hsync_n and vsync_n change only on a tick.
- R3: Each line lasts H_FRONT + H_SYNC + H_BACK + BORDER_L + IMAGE_W + BORDER_R ticks (32+64+42+40+640+40 = 858 by default). The phases run in this order: porch before sync, sync, porch before visible, left border, image, right border.
- R4: hsync_n is 0 during the sync phase of every line, including lines in vertical blanking, and is 1 at all other times.
- R5: Each frame lasts V_SYNC + V_TOP + V_ACT + V_BOT lines (2+25+480+18 = 525 by default), in that order. vsync_n is 0 for the whole of each sync line and 1 on every other line.
- R6: de is 1 only on the BORDER_L + IMAGE_W + BORDER_R visible pixels of active lines. Whenever de is 0, rgb_out is 0.
- R7: The left border pixels show border_left and the right border pixels show border_right, each taken at the tick that registers the pixel.
- R8: An image word holds red in bits [15:11], green in [10:5] and blue in [4:0]. rgb_out holds red in [23:16], green in [15:8] and blue in [7:0]. Each channel is the 5- or 6-bit value followed by copies of its own top bits until it is 8 bits wide.
- R9: pix_ready is 1 for exactly one clock, the tick clock, of each image pixel on an active line, and is 0 at all other times. A word is taken only when pix_ready and pix_valid are both 1, so at most one word is taken per image pixel and none during borders or blanking.
- R10: If pix_valid is 0 at the tick of an image pixel, that pixel is shown as black with de at 1, and underflow goes to 1.
- R11: Once set, underflow stays 1 until reset clears it. It never sets while every image pixel is supplied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_valid | input | 1 | An image word is on pix_data |
| pix_data | input | 16 | Image word, 5:6:5 red/green/blue |
| pix_ready | output | 1 | Word taken at this clock edge if valid |
| border_left | input | 24 | Colour of the left border span |
| border_right | input | 24 | Colour of the right border span |
| rgb_out | output | 24 | Registered pixel colour, 8 bits per channel |
| de | output | 1 | Visible pixel on an active line |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| underflow | output | 1 | Sticky: an image pixel found no word |

## Verification
The checks assume the image source follows the usual stream rule. Once a source raises pix_valid, it holds that signal and pix_data steady until a clock edge with pix_ready high takes the word, and only then may it drop valid or present a new word. The stimulus follows this rule by choosing valid and data at random only at the start of a pixel period that comes after a word was taken, or when valid was low. The border colours change only at pixel boundaries, so each one is steady when its tick samples it. The bench shortens every span through the parameters so that several full frames fit in a short run.

// File: rtl/scan480_pkg.sv
package scan480_pkg;

  // Widen 5:6:5 into 8:8:8 by repeating each channel's top bits below it.
  function automatic logic [23:0] widen565(input logic [15:0] w);
    logic [4:0] r5;
    logic [5:0] g6;
    logic [4:0] b5;
    r5 = w[15:11];
    g6 = w[10:5];
    b5 = w[4:0];
    return {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
  endfunction

  // Counter step with wrap at a terminal value.
  function automatic int unsigned wrap_step(input int unsigned cur, input int unsigned last);
    return (cur == last) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/scan480_tick.sv
module scan480_tick #(
  parameter int unsigned CLK_DIV = 10
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);

  logic [DW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)               phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign tick = (phase == LAST);
endmodule

// File: rtl/scan480_timing.sv
module scan480_timing #(
  parameter int unsigned H_FRONT  = 32,
  parameter int unsigned H_SYNC   = 64,
  parameter int unsigned H_BACK   = 42,
  parameter int unsigned BORDER_L = 40,
  parameter int unsigned IMAGE_W  = 640,
  parameter int unsigned BORDER_R = 40,
  parameter int unsigned V_SYNC   = 2,
  parameter int unsigned V_TOP    = 25,
  parameter int unsigned V_ACT    = 480,
  parameter int unsigned V_BOT    = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic in_hsync,
  output logic in_left,
  output logic in_image,
  output logic in_right,
  output logic in_vsync,
  output logic in_active
);
  import scan480_pkg::*;

  localparam int unsigned HS0 = H_FRONT;
  localparam int unsigned HB0 = HS0 + H_SYNC;
  localparam int unsigned HL0 = HB0 + H_BACK;
  localparam int unsigned HI0 = HL0 + BORDER_L;
  localparam int unsigned HR0 = HI0 + IMAGE_W;
  localparam int unsigned HT  = HR0 + BORDER_R;
  localparam int unsigned VA0 = V_SYNC + V_TOP;
  localparam int unsigned VB0 = VA0 + V_ACT;
  localparam int unsigned VT  = VB0 + V_BOT;
  localparam int unsigned HW  = $clog2(HT);
  localparam int unsigned VW  = $clog2(VT);

  logic [HW-1:0] hpos;
  logic [VW-1:0] vpos;
  logic          line_last;

  assign line_last = (hpos == HW'(HT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hpos <= '0;
      vpos <= '0;
    end else if (tick) begin
      hpos <= HW'(wrap_step(32'(hpos), HT - 1));
      if (line_last) vpos <= VW'(wrap_step(32'(vpos), VT - 1));
    end
  end

  always_comb begin
    in_hsync  = (hpos >= HW'(HS0)) && (hpos < HW'(HB0));
    in_left   = (hpos >= HW'(HL0)) && (hpos < HW'(HI0));
    in_image  = (hpos >= HW'(HI0)) && (hpos < HW'(HR0));
    in_right  = (hpos >= HW'(HR0));
    in_vsync  = (vpos < VW'(V_SYNC));
    in_active = (vpos >= VW'(VA0)) && (vpos < VW'(VB0));
  end
endmodule

// File: rtl/scan480_pixel_path.sv
module scan480_pixel_path (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        in_hsync,
  input  logic        in_left,
  input  logic        in_image,
  input  logic        in_right,
  input  logic        in_vsync,
  input  logic        in_active,
  input  logic        pix_valid,
  input  logic [15:0] pix_data,
  input  logic [23:0] border_left,
  input  logic [23:0] border_right,
  output logic        pix_ready,
  output logic        take,
  output logic        starve,
  output logic [23:0] rgb_out,
  output logic        de,
  output logic        hsync_n,
  output logic        vsync_n,
  output logic        underflow
);
  import scan480_pkg::*;

  logic        img_slot;
  logic        vis_slot;
  logic [23:0] colour_nxt;

  assign img_slot  = in_active && in_image;
  assign vis_slot  = in_active && (in_left || in_image || in_right);
  assign pix_ready = tick && img_slot;
  assign take      = pix_ready && pix_valid;
  assign starve    = pix_ready && !pix_valid;

  always_comb begin
    colour_nxt = '0;
    if (in_active) begin
      if (in_left)                     colour_nxt = border_left;
      else if (in_right)               colour_nxt = border_right;
      else if (in_image && pix_valid)  colour_nxt = widen565(pix_data);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rgb_out   <= '0;
      de        <= 1'b0;
      hsync_n   <= 1'b1;
      vsync_n   <= 1'b1;
      underflow <= 1'b0;
    end else begin
      if (tick) begin
        rgb_out <= colour_nxt;
        de      <= vis_slot;
        hsync_n <= !in_hsync;
        vsync_n <= !in_vsync;
      end
      if (starve) underflow <= 1'b1;
    end
  end
endmodule

// File: rtl/scan480_sequencer.sv
module scan480_sequencer #(
  parameter int unsigned CLK_DIV  = 10,
  parameter int unsigned H_FRONT  = 32,
  parameter int unsigned H_SYNC   = 64,
  parameter int unsigned H_BACK   = 42,
  parameter int unsigned BORDER_L = 40,
  parameter int unsigned IMAGE_W  = 640,
  parameter int unsigned BORDER_R = 40,
  parameter int unsigned V_SYNC   = 2,
  parameter int unsigned V_TOP    = 25,
  parameter int unsigned V_ACT    = 480,
  parameter int unsigned V_BOT    = 18
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pix_valid,
  input  logic [15:0] pix_data,
  output logic        pix_ready,
  input  logic [23:0] border_left,
  input  logic [23:0] border_right,
  output logic [23:0] rgb_out,
  output logic        de,
  output logic        hsync_n,
  output logic        vsync_n,
  output logic        underflow
);
  // Named internal events, brought out for the checker.
  logic tick;
  logic take;
  logic starve;
  logic in_hsync, in_left, in_image, in_right, in_vsync, in_active;

  scan480_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  scan480_timing #(
    .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .BORDER_L(BORDER_L), .IMAGE_W(IMAGE_W), .BORDER_R(BORDER_R),
    .V_SYNC(V_SYNC), .V_TOP(V_TOP), .V_ACT(V_ACT), .V_BOT(V_BOT)
  ) u_timing (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .in_hsync (in_hsync),
    .in_left  (in_left),
    .in_image (in_image),
    .in_right (in_right),
    .in_vsync (in_vsync),
    .in_active(in_active)
  );

  scan480_pixel_path u_path (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .in_hsync    (in_hsync),
    .in_left     (in_left),
    .in_image    (in_image),
    .in_right    (in_right),
    .in_vsync    (in_vsync),
    .in_active   (in_active),
    .pix_valid   (pix_valid),
    .pix_data    (pix_data),
    .border_left (border_left),
    .border_right(border_right),
    .pix_ready   (pix_ready),
    .take        (take),
    .starve      (starve),
    .rgb_out     (rgb_out),
    .de          (de),
    .hsync_n     (hsync_n),
    .vsync_n     (vsync_n),
    .underflow   (underflow)
  );
endmodule

// File: rtl/scan480_checks.sv
module scan480_checks (
  input logic        clk,
  input logic        rst,
  input logic        tick,
  input logic        take,
  input logic        starve,
  input logic        pix_valid,
  input logic        pix_ready,
  input logic [15:0] pix_data,
  input logic [23:0] rgb_out,
  input logic        de,
  input logic        hsync_n,
  input logic        vsync_n,
  input logic        underflow
);
  import scan480_pkg::*;

  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(rgb_out) && $stable(de) && $stable(hsync_n) && $stable(vsync_n)));

  p_no_sync_in_visible_r4: assert property (@(posedge clk) disable iff (rst)
    de |-> (hsync_n && vsync_n));

  p_dark_outside_r6: assert property (@(posedge clk) disable iff (rst)
    !de |-> (rgb_out == 24'h0));

  p_take_widens_r8: assert property (@(posedge clk) disable iff (rst)
    take |=> (de && rgb_out == widen565($past(pix_data))));

  p_ready_single_r9: assert property (@(posedge clk) disable iff (rst)
    pix_ready |=> !pix_ready);

  p_input_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)));

  p_starve_black_r10: assert property (@(posedge clk) disable iff (rst)
    starve |=> (de && rgb_out == 24'h0 && underflow));

  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);
endmodule

bind scan480_sequencer scan480_checks u_checks (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .take     (take),
  .starve   (starve),
  .pix_valid(pix_valid),
  .pix_ready(pix_ready),
  .pix_data (pix_data),
  .rgb_out  (rgb_out),
  .de       (de),
  .hsync_n  (hsync_n),
  .vsync_n  (vsync_n),
  .underflow(underflow)
);

// File: tb/scan480_sequencer_bench.sv
`timescale 1ns/1ps
module scan480_sequencer_bench;
  localparam int DIV = 2;
  localparam int HF = 2, HS = 3, HB = 2, BL = 2, IM = 6, BR = 2;
  localparam int VS = 2, VTP = 2, VA = 3, VBT = 1;
  localparam int HT = HF + HS + HB + BL + IM + BR;
  localparam int VT = VS + VTP + VA + VBT;
  localparam int FRAME = HT * VT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_valid = 1'b0;
  logic [15:0] pix_data = '0;
  logic pix_ready;
  logic [23:0] border_left = '0, border_right = '0;
  logic [23:0] rgb_out;
  logic de, hsync_n, vsync_n, underflow;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  scan480_sequencer #(
    .CLK_DIV(DIV), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .BORDER_L(BL), .IMAGE_W(IM), .BORDER_R(BR),
    .V_SYNC(VS), .V_TOP(VTP), .V_ACT(VA), .V_BOT(VBT)
  ) u_scan480_sequencer (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .border_left(border_left), .border_right(border_right),
    .rgb_out(rgb_out), .de(de), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .underflow(underflow)
  );

  // Bench restatement of the 5:6:5 widening (R8).
  function automatic logic [23:0] ref_widen(input logic [15:0] w);
    int r, g, b;
    r = (w >> 11) & 31;
    g = (w >> 5) & 63;
    b = w & 31;
    return 24'(((r * 8 + r / 4) << 16) | ((g * 4 + g / 16) << 8) | (b * 8 + b / 4));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(rgb_out == 0, {tag, " rgb"}, 32'(rgb_out), 0);
    chk(de == 0, {tag, " de"}, 32'(de), 0);
    chk(hsync_n && vsync_n, {tag, " syncs"}, {hsync_n, vsync_n}, 2'b11);
    chk(underflow == 0, {tag, " underflow"}, 32'(underflow), 0);
    chk(pix_ready == 0, {tag, " ready"}, 32'(pix_ready), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] prev_rgb;
    logic prev_de, prev_hs, prev_vs;
    bit exp_uf;
    bit consumed;
    bit uf_seen_clean;
    void'($urandom(32'h5CA9_0480));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle("R1 in reset");
    rst = 1'b0;
    exp_uf = 0;
    consumed = 1;
    uf_seen_clean = 0;
    prev_rgb = '0; prev_de = 0; prev_hs = 1; prev_vs = 1;
    for (int s = 0; s < 3 * FRAME; s++) begin
      int f, h, v, vis0;
      bit act_line, vis, is_img, got;
      logic [23:0] exp_rgb;
      f = s / FRAME;
      h = s % HT;
      v = (s / HT) % VT;
      // Source drive at the start of the pixel period.
      if (!pix_valid || consumed) begin
        if (f == 0) pix_valid = 1'b1;
        else if (f == 1 && v == VS + VTP) pix_valid = 1'b0;
        else pix_valid = ($urandom_range(3) != 0);
        pix_data = 16'($urandom);
      end
      if (h == 0) begin
        border_left  = 24'($urandom);
        border_right = 24'($urandom);
      end
      // R1: the first pixel period after reset keeps the reset values.
      if (s == 0) chk_idle("R1 before first tick");
      // R2: outputs hold between ticks.
      for (int k = 0; k < DIV - 1; k++) begin
        @(posedge clk); @(negedge clk);
        chk(rgb_out == prev_rgb && de == prev_de && hsync_n == prev_hs && vsync_n == prev_vs,
            "R2 hold between ticks", {rgb_out, de, hsync_n, vsync_n}, {prev_rgb, prev_de, prev_hs, prev_vs});
      end
      act_line = (v >= VS + VTP) && (v < VS + VTP + VA);
      vis0 = HT - (BL + IM + BR);
      vis = act_line && (h >= vis0);
      is_img = vis && (h >= HT - IM - BR) && (h < HT - BR);
      // R9: ready only at the tick clock of image pixels.
      chk(pix_ready == is_img, "R9 ready", 32'(pix_ready), 32'(is_img));
      got = pix_valid;
      @(posedge clk); @(negedge clk);
      consumed = is_img && got;
      if (!vis) exp_rgb = '0;
      else if (h < HT - IM - BR) exp_rgb = border_left;
      else if (h >= HT - BR) exp_rgb = border_right;
      else exp_rgb = got ? ref_widen(pix_data) : 24'h0;
      if (is_img && !got) exp_uf = 1;
      chk(de == vis, "R6 de", 32'(de), 32'(vis));
      if (!vis) chk(rgb_out == 0, "R6 dark", 32'(rgb_out), 0);
      else if (!is_img) chk(rgb_out == exp_rgb, "R7 border", 32'(rgb_out), 32'(exp_rgb));
      else if (got) chk(rgb_out == exp_rgb, "R8 widen", 32'(rgb_out), 32'(exp_rgb));
      else chk(rgb_out == 0, "R10 black", 32'(rgb_out), 0);
      chk(hsync_n == !((h >= HF) && (h < HF + HS)), "R3 R4 hsync", 32'(hsync_n), 32'(!((h >= HF) && (h < HF + HS))));
      chk(vsync_n == !(v < VS), "R5 vsync", 32'(vsync_n), 32'(!(v < VS)));
      chk(underflow == exp_uf, "R10 R11 underflow", 32'(underflow), 32'(exp_uf));
      if (s == FRAME - 1) begin
        uf_seen_clean = (underflow == 0);
        chk(uf_seen_clean, "R11 clean frame", 32'(underflow), 0);
      end
      prev_rgb = rgb_out; prev_de = de; prev_hs = hsync_n; prev_vs = vsync_n;
    end
    chk(underflow == 1, "R11 still set", 32'(underflow), 1);
    rst = 1'b1;
    pix_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk_idle("R1 R11 reset clears");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule